// File: doc/BRIEF.md
# Translation Cache Range Invalidation Engine

This block owns a small, fully associative cache of I/O page-table entry tags and a 64-bit memory-mapped command register. Software starts an invalidation by writing one register word. The word holds an entry count, the physical address of the first 8-byte page-table entry and a start flag. The engine then walks the range one entry per clock. At each step it compares the current entry address with every cached tag and drops the valid bit of each line that matches.

While the walk runs, the low bit of the register reads back as 1. Software polls until that bit reads 0. A range longer than one command can cover is split by software into several commands, with a wait for completion between them. The tag array is loaded through a fill port. The logic that fetches entries from memory and the translation path sit outside this block.

Top module: `tcinv_engine`

## Requirements
- R1: After reset, every cache line is invalid, the busy bit reads 0, and the command register reads back as all zeros.
- R2: A command starts only on a write to byte offset 0x908 of the 13-bit register window with bit 0 set. A write to any other offset changes neither the register nor the cache.
- R3: A read at offset 0x908 returns the count in bits 63:53, the start entry address (entry index in 8-byte units) in bits 41:3, and busy in bit 0, with all other bits 0. A read at any other offset returns 0.
- R4: After the accepting clock edge, busy reads 1 for exactly N cycles. N is the count field, and a count field of 0 means 2048 entries.
- R5: Entry k of a command has address start+k, in 8-byte units. Every valid line whose tag equals one of the N entry addresses is invalidated, and this includes several lines that hold the same tag. Lines whose tags fall outside the range keep their valid bit.
- R6: Entry k is compared and cleared on clock edge k+1 after the accepting edge, one entry per clock.
- R7: A command write that arrives while busy is 1 is ignored. The register fields and the running walk are unchanged.
- R8: A write to 0x908 with bit 0 clear is ignored.
- R9: A fill makes its line valid with the given tag. If a fill and a walk clear hit the same line on the same edge, the fill wins and the line stays valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 13 | Byte offset within the register window |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data for the offset on regAddr |
| fillEn | input | 1 | Load one cache line |
| fillIdx | input | 3 | Line index to load |
| fillTag | input | 39 | Entry address tag for the loaded line |
| lineValid | output | 8 | Valid bit of each cache line |

## Verification
Several properties are checked on every cycle. The remaining count stays nonzero while busy is set. Busy falls only after the last step. A write during a walk neither restarts the walk nor changes the stored fields. A line hit by a step is invalid on the next cycle unless a fill targets it, and lines see no valid change when neither a step nor a fill touches them.

Other behaviours depend on scenarios and are left to the bench's reference model. These are the exact busy duration, including the 2048-entry case for a zero count, the read-back format, the offset decode, the ignored write with bit 0 clear, and the edge on which each line drops. They also include the correct treatment of duplicate tags and of tags just past the range.

// File: rtl/tcinv_pkg.sv
package tcinv_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture a new command
    logic step;   // compare and clear for the current entry
  } ctrl_strobe_t;
endpackage

// File: rtl/tcinv_ctrl.sv
module tcinv_ctrl
  import tcinv_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic [CNT_W-1:0] cntField,
  output ctrl_strobe_t     strobe,
  output logic             busy
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] MAX_RUN = REM_W'(1) << CNT_W;

  logic [REM_W-1:0] remain;

  always_comb begin
    strobe.load = cmdWrite && !busy;
    strobe.step = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      remain <= (cntField == '0) ? MAX_RUN : {1'b0, cntField};
    end else if (busy) begin
      remain <= remain - 1'b1;
      if (remain == REM_W'(1)) busy <= 1'b0;
    end
  end

  // R4: a running walk always has work left
  p_remain_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (remain != '0 && remain <= MAX_RUN));

  // R4: busy ends only after the final entry
  p_finish_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(remain) == REM_W'(1));

  // R7: a command during a walk does not reload the counter
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite && remain > REM_W'(1)) |=> (busy && remain == $past(remain) - 1'b1));
endmodule

// File: rtl/tcinv_dp.sv
module tcinv_dp
  import tcinv_pkg::*;
#(
  parameter int          LINES   = 8,
  parameter int          IDX_W   = 3,
  parameter int          ADDR_W  = 39,
  parameter int          CNT_W   = 11,
  parameter int          WIN_W   = 13,
  parameter logic [12:0] CMD_OFS = 13'h908
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              busy,
  input  logic [WIN_W-1:0]  regAddr,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] fillTag,
  output logic [LINES-1:0]  lineValid,
  output logic              cmdWrite,
  output logic [CNT_W-1:0]  cntField
);
  localparam int ADDR_LO = 3;
  localparam int CNT_LO  = 64 - CNT_W;
  localparam int GAP_W   = 64 - CNT_W - ADDR_W - ADDR_LO;

  logic              offsetHit;
  logic              wrHit;
  logic [ADDR_W-1:0] addrField;
  logic [CNT_W-1:0]  cmdCnt;
  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] tagArr [LINES];
  logic [LINES-1:0]  valid;
  logic [LINES-1:0]  hit;
  logic [LINES-1:0]  fillOn;

  // Register decode
  always_comb begin
    offsetHit = (regAddr == CMD_OFS[WIN_W-1:0]);
    wrHit     = regWrEn && offsetHit;
    cmdWrite  = wrHit && regWrData[0];
    cntField  = regWrData[63:CNT_LO];
    addrField = regWrData[ADDR_LO+ADDR_W-1:ADDR_LO];
  end

  // Command fields and walk pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCnt  <= '0;
      cmdAddr <= '0;
      curAddr <= '0;
    end else if (strobe.load) begin
      cmdCnt  <= cntField;
      cmdAddr <= addrField;
      curAddr <= addrField;
    end else if (strobe.step) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // Tag array: compare every line against the current entry
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hit[i]    = valid[i] && (tagArr[i] == curAddr);
    assign fillOn[i] = fillEn && (fillIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valid[i]  <= 1'b0;
        tagArr[i] <= '0;
      end else if (fillOn[i]) begin
        valid[i]  <= 1'b1;
        tagArr[i] <= fillTag;
      end else if (strobe.step && hit[i]) begin
        valid[i]  <= 1'b0;
      end
    end

    // R5: a hit during a step leaves the line invalid
    p_clear_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && hit[i] && !fillOn[i]) |=> !lineValid[i]);

    // R5: no step and no fill means no change
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.step && !fillOn[i]) |=> $stable(lineValid[i]));

    // R9: a fill always leaves its line valid
    p_fill_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      fillOn[i] |=> lineValid[i]);
  end

  assign lineValid = valid;

  // Read-back
  always_comb begin
    if (offsetHit)
      regRdData = {cmdCnt, {GAP_W{1'b0}}, cmdAddr, 2'b00, busy};
    else
      regRdData = '0;
  end

  // R7: fields hold while a walk runs
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrHit) |=> ($stable(cmdAddr) && $stable(cmdCnt)));
endmodule

// File: rtl/tcinv_engine.sv
module tcinv_engine
  import tcinv_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = $clog2(LINES),
  parameter int ADDR_W = 39,
  parameter int CNT_W  = 11,
  parameter int WIN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIN_W-1:0]  regAddr,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] fillTag,
  output logic [LINES-1:0]  lineValid
);
  ctrl_strobe_t     strobe;
  logic             busy;
  logic             cmdWrite;
  logic [CNT_W-1:0] cntField;

  tcinv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .cntField (cntField),
    .strobe   (strobe),
    .busy     (busy)
  );

  tcinv_dp #(
    .LINES  (LINES),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WIN_W  (WIN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .fillEn    (fillEn),
    .fillIdx   (fillIdx),
    .fillTag   (fillTag),
    .lineValid (lineValid),
    .cmdWrite  (cmdWrite),
    .cntField  (cntField)
  );
endmodule

// File: tb/tcinv_engine_bench.sv
`timescale 1ns/1ps
module tcinv_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] regAddr = 13'h908;
  logic        regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        fillEn = 1'b0;
  logic [2:0]  fillIdx = '0;
  logic [38:0] fillTag = '0;
  logic [7:0]  lineValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcinv_engine u_tcinv_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .fillEn(fillEn),
    .fillIdx(fillIdx), .fillTag(fillTag), .lineValid(lineValid)
  );

  // Behavioural reference: a queue of pending entry addresses.
  logic [38:0] mTag [8];
  bit          mValid [8];
  logic [38:0] pend [$];
  logic [10:0] mCnt;
  logic [38:0] mAddr;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mValid[i] = 0; mTag[i] = '0; end
      pend.delete();
      mCnt = '0; mAddr = '0;
    end else begin
      bit wasBusy;
      wasBusy = (pend.size() != 0);
      if (wasBusy) begin
        logic [38:0] a;
        a = pend.pop_front();
        for (int i = 0; i < 8; i++) if (mValid[i] && mTag[i] == a) mValid[i] = 0;
      end
      if (regWrEn && regAddr == 13'h908 && regWrData[0] && !wasBusy) begin
        int n;
        mCnt  = regWrData[63:53];
        mAddr = regWrData[41:3];
        n = (mCnt == 0) ? 2048 : int'(mCnt);
        for (int k = 0; k < n; k++) pend.push_back(mAddr + 39'(k));
      end
      if (fillEn) begin mValid[fillIdx] = 1; mTag[fillIdx] = fillTag; end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelValid();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mValid[i];
    return v;
  endfunction

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [63:0] expRd;
      expRd = (regAddr == 13'h908) ?
              {mCnt, 11'b0, mAddr, 2'b00, (pend.size() != 0)} : 64'd0;
      chk(lineValid == modelValid(), "R5/R6 lineValid per cycle",
          64'(lineValid), 64'(modelValid()));
      chk(regRdData == expRd, "R3/R4 read-back per cycle", regRdData, expRd);
    end
  end

  function automatic logic [63:0] mk(logic [10:0] c, logic [38:0] a, bit go);
    return {c, 11'b0, a, 2'b00, go};
  endfunction

  task automatic issue(logic [12:0] a, logic [63:0] d);
    @(posedge clk); #2;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #2;
    regWrEn = 1'b0; regAddr = 13'h908;
  endtask

  task automatic fill(logic [2:0] idx, logic [38:0] tag);
    @(posedge clk); #2;
    fillEn = 1'b1; fillIdx = idx; fillTag = tag;
    @(posedge clk); #2;
    fillEn = 1'b0;
  endtask

  task automatic measureBusy(output int n);
    n = 0;
    @(negedge clk);
    while (regRdData[0] && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic idle(int c);
    repeat (c) @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [38:0] t;
    int n;
    t = 39'h100;
    repeat (3) @(posedge clk);
    #2; rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lineValid == 8'h00, "R1 lines invalid", 64'(lineValid), 64'h0);
    chk(regRdData == 64'd0, "R1 read-back zero", regRdData, 64'd0);

    fill(3'd0, t);       fill(3'd1, t + 39'd1); fill(3'd2, t + 39'd2);
    fill(3'd3, t + 39'd3); fill(3'd4, t + 39'd20); fill(3'd5, t - 39'd1);
    fill(3'd6, 39'h7F_0000); fill(3'd7, t + 39'd2);
    @(negedge clk);
    chk(lineValid == 8'hFF, "R9 fills valid", 64'(lineValid), 64'hFF);

    // R3, R4, R5: count 3 from t
    issue(13'h908, mk(11'd3, t, 1'b1));
    @(negedge clk);
    chk(regRdData == mk(11'd3, t, 1'b1), "R3 read-back while busy", regRdData, mk(11'd3, t, 1'b1));
    idle(4);
    @(negedge clk);
    chk(lineValid == 8'h78, "R5 range cleared incl duplicate", 64'(lineValid), 64'h78);

    // R4 duration for count 5
    issue(13'h908, mk(11'd5, 39'h5000, 1'b1));
    measureBusy(n);
    chk(n == 5, "R4 busy cycles count 5", 64'(n), 64'd5);

    // R6: line4 tag t+20 is entry 4 of a walk from t+16
    issue(13'h908, mk(11'd8, t + 39'd16, 1'b1));
    repeat (4) @(negedge clk);
    @(negedge clk);
    chk(lineValid[4] == 1'b1, "R6 line valid before its step", 64'(lineValid[4]), 64'd1);
    @(negedge clk);
    chk(lineValid[4] == 1'b0, "R6 line cleared on step 5", 64'(lineValid[4]), 64'd0);
    idle(4);

    // R7: write during a walk ignored
    issue(13'h908, mk(11'd10, t + 39'd3, 1'b1));
    issue(13'h908, mk(11'd5, 39'h7F_0000, 1'b1));
    idle(12);
    @(negedge clk);
    chk(lineValid[6] == 1'b1, "R7 second command had no effect", 64'(lineValid[6]), 64'd1);
    chk(regRdData == mk(11'd10, t + 39'd3, 1'b0), "R7 fields kept", regRdData, mk(11'd10, t + 39'd3, 1'b0));

    // R8: bit 0 clear
    issue(13'h908, mk(11'd1, 39'h7F_0000, 1'b0));
    @(negedge clk);
    chk(regRdData == mk(11'd10, t + 39'd3, 1'b0), "R8 no start", regRdData, mk(11'd10, t + 39'd3, 1'b0));
    idle(2);
    @(negedge clk);
    chk(lineValid[6] == 1'b1, "R8 line kept", 64'(lineValid[6]), 64'd1);

    // R2: other offset
    issue(13'h910, mk(11'd1, 39'h7F_0000, 1'b1));
    @(negedge clk);
    chk(regRdData == mk(11'd10, t + 39'd3, 1'b0), "R2 other offset ignored", regRdData, mk(11'd10, t + 39'd3, 1'b0));
    idle(2);
    @(negedge clk);
    chk(lineValid[6] == 1'b1, "R2 line kept", 64'(lineValid[6]), 64'd1);
    #2; regAddr = 13'h910;
    @(negedge clk);
    chk(regRdData == 64'd0, "R3 other offset reads zero", regRdData, 64'd0);
    #2; regAddr = 13'h908;

    // R9: fill and clear on the same edge
    fill(3'd3, 39'h2_0000);
    @(posedge clk); #2;
    regWrData = mk(11'd2, 39'h2_0000, 1'b1); regWrEn = 1'b1;
    @(posedge clk); #2;
    regWrEn = 1'b0; fillEn = 1'b1; fillIdx = 3'd3; fillTag = 39'h2_0000;
    @(posedge clk); #2;
    fillEn = 1'b0;
    idle(3);
    @(negedge clk);
    chk(lineValid[3] == 1'b1, "R9 fill wins over clear", 64'(lineValid[3]), 64'd1);

    // R4, R5: count 0 means 2048
    fill(3'd0, 39'h40_0000 + 39'd2047);
    fill(3'd1, 39'h40_0000 + 39'd2048);
    issue(13'h908, mk(11'd0, 39'h40_0000, 1'b1));
    measureBusy(n);
    chk(n == 2048, "R4 zero count runs 2048", 64'(n), 64'd2048);
    @(negedge clk);
    chk(lineValid[0] == 1'b0, "R5 last entry cleared", 64'(lineValid[0]), 64'd0);
    chk(lineValid[1] == 1'b1, "R5 entry past range kept", 64'(lineValid[1]), 64'd1);

    // R4: count 1
    issue(13'h908, mk(11'd1, 39'h9, 1'b1));
    measureBusy(n);
    chk(n == 1, "R4 busy cycles count 1", 64'(n), 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule